// File: doc/BRIEF.md
# Class-of-Service Cache Mask Table

This block is the per-socket store of cache capacity masks. Each mask is a bit vector, one bit per cache way group. A set bit means that a class of service may allocate into that group. There are two independent banks: one for an inner cache level and one for an outer cache level. Both banks are looked up with the same class-of-service value. Each bank has its own entry count, and therefore its own highest valid class. The lookup port takes a class, a level select and an access kind (code or data). One cycle later it returns the mask that a way-selection stage applies to the access.

Software fills the banks through a write port addressed by mask index, and can read any entry back through a registered read port. Every written value is checked. The value must be a single unbroken run of ones, and it must not be zero. Entry 0 of each bank is the fully open default mask, and it cannot be altered. A mode bit turns on split code/data operation for the outer bank. In that mode the outer entries are treated as pairs, one mask for data fetches and one for code fetches, and only the lower half of the class range stays usable.

Top module: `cosmask_table`

## Requirements
- R1: After reset every entry of both banks holds the default mask, split mode is off, `wrErr` is low, and `lkMask` and `rdMask` both show the default mask.
- R2: The default mask is all ones over `MASK_W` bits, that is (1 << MASK_W) - 1. A lookup with class 0 returns it on either level and in either mode. A legal write to index 0 of either bank is dropped without an error, and reading index 0 back still gives all ones.
- R3: A write of a legal mask to a nonzero, in-range index stores that mask. A read of that index issued in any later cycle returns the mask on `rdMask` one cycle after the read is presented. A read of an inner index at or beyond `INNER_ENTRIES` returns the default mask.
- R4: A write whose mask is zero, or whose set bits do not form one contiguous run, leaves every entry unchanged. `wrErr` is high in exactly the cycle after that write.
- R5: A write to the inner bank at an index at or beyond `INNER_ENTRIES` leaves every entry unchanged and raises `wrErr` in the following cycle.
- R6: With split mode off, an outer lookup of class c in 1..OUTER_ENTRIES-1 returns outer entry c, whatever the access kind. Any larger class returns the default mask.
- R7: An inner lookup of class c in 1..INNER_ENTRIES-1 returns inner entry c. Any larger class returns the default mask. The access kind and the mode bit have no effect on inner lookups.
- R8: With split mode on, an outer lookup of class c in 1..OUTER_ENTRIES/2-1 returns outer entry 2c for data (`lkCode`=0) and entry 2c+1 for code (`lkCode`=1). A class of OUTER_ENTRIES/2 or more returns the default mask.
- R9: A mode write loads `modeSplit` into the mode bit. `splitActive` shows the new value one cycle later, and lookups presented in that same cycle still use the old mode. Stored entries keep their values across a mode change.
- R10: `lkMask` is registered: it shows the result for the lookup inputs present at the previous clock edge. When a write and a lookup of the same entry happen in one cycle, the lookup returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Mask write strobe |
| wrOuter | input | 1 | Write bank select: 1 selects the outer bank, 0 the inner bank |
| wrIdx | input | $clog2(OUTER_ENTRIES) | Mask index to write |
| wrMask | input | MASK_W | Mask value to write |
| modeWrEn | input | 1 | Mode bit write strobe |
| modeSplit | input | 1 | New mode value: 1 selects split code/data |
| rdOuter | input | 1 | Read bank select: 1 selects the outer bank |
| rdIdx | input | $clog2(OUTER_ENTRIES) | Mask index to read |
| rdMask | output | MASK_W | Registered read data |
| lkCos | input | COS_W | Class of service of the access |
| lkOuter | input | 1 | Lookup level: 1 selects the outer bank |
| lkCode | input | 1 | Access kind: 1 for code, 0 for data |
| lkMask | output | MASK_W | Registered mask for the access |
| wrErr | output | 1 | One-cycle pulse for a rejected write |
| splitActive | output | 1 | Current mode bit |

## Verification
The bench uses the default parameters: 8-bit masks, 16 outer entries, 8 inner entries and a 5-bit class field. With a 5-bit class, lookups of classes 16 to 31 go past the outer limit in plain mode. Classes 8 to 31 go past both the split-mode limit and the inner limit. Every one of these default cases is reachable. With 8-bit masks, the full mask with the top bit set and the one-bit masks at each end can all be tried. Gapped patterns and the zero value are also in reach. A behavioural model runs alongside the block and is compared every cycle. It covers directed fills, same-cycle write and lookup collisions, mode flips, and a long run of random traffic.

// File: rtl/cosmask_pkg.sv
package cosmask_pkg;

  // Write strobes handed from control to datapath
  typedef struct packed {
    logic wrOuter;  // commit wrMask into the outer bank
    logic wrInner;  // commit wrMask into the inner bank
  } cmStrobe_t;

  typedef enum logic {
    ACC_DATA = 1'b0,
    ACC_CODE = 1'b1
  } accKind_e;

endpackage

// File: rtl/cosmask_ctrl.sv
module cosmask_ctrl
  import cosmask_pkg::*;
#(
  parameter int MASK_W        = 8,
  parameter int OUTER_ENTRIES = 16,
  parameter int INNER_ENTRIES = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic                             wrOuter,
  input  logic [$clog2(OUTER_ENTRIES)-1:0] wrIdx,
  input  logic [MASK_W-1:0]                wrMask,
  input  logic                             modeWrEn,
  input  logic                             modeSplit,
  output cmStrobe_t                        stb,
  output logic                             wrErr,
  output logic                             splitQ
);
  localparam int IDX_W = $clog2(OUTER_ENTRIES);

  logic [MASK_W:0] maskExt;
  logic [MASK_W:0] filled;
  logic [MASK_W:0] carried;
  logic            maskOk;
  logic            idxOk;
  logic            accept;
  logic            reject;

  // Fill below the lowest one, add one: a single run leaves no overlap
  always_comb begin
    maskExt = {1'b0, wrMask};
    filled  = maskExt | (maskExt - 1'b1);
    carried = filled + 1'b1;
    maskOk  = (wrMask != '0) && ((carried & maskExt) == '0);
  end

  assign idxOk  = wrOuter || ({1'b0, wrIdx} < (IDX_W+1)'(INNER_ENTRIES));
  assign accept = wrEn && maskOk && idxOk;
  assign reject = wrEn && !(maskOk && idxOk);

  // Index 0 is the locked default: legal writes to it are silently dropped
  assign stb.wrOuter = accept && wrOuter  && (wrIdx != '0);
  assign stb.wrInner = accept && !wrOuter && (wrIdx != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErr  <= 1'b0;
      splitQ <= 1'b0;
    end else begin
      wrErr <= reject;
      if (modeWrEn) splitQ <= modeSplit;
    end
  end

  // R4
  errNeedsWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrEn));

  // R2
  lockedIdx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrOuter || stb.wrInner) |-> (wrIdx != '0));

  // R9
  modeFollows_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeWrEn) |-> (splitQ == $past(modeSplit)));

endmodule

// File: rtl/cosmask_dp.sv
module cosmask_dp
  import cosmask_pkg::*;
#(
  parameter int MASK_W        = 8,
  parameter int OUTER_ENTRIES = 16,
  parameter int INNER_ENTRIES = 8,
  parameter int COS_W         = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cmStrobe_t                        stb,
  input  logic [$clog2(OUTER_ENTRIES)-1:0] wrIdx,
  input  logic [MASK_W-1:0]                wrMask,
  input  logic                             splitQ,
  input  logic                             rdOuter,
  input  logic [$clog2(OUTER_ENTRIES)-1:0] rdIdx,
  output logic [MASK_W-1:0]                rdMask,
  input  logic [COS_W-1:0]                 lkCos,
  input  logic                             lkOuter,
  input  logic                             lkCode,
  output logic [MASK_W-1:0]                lkMask
);
  localparam int               IDX_W    = $clog2(OUTER_ENTRIES);
  localparam int               IN_W     = $clog2(INNER_ENTRIES);
  localparam logic [MASK_W-1:0] DEF_MASK = {MASK_W{1'b1}};
  localparam logic [COS_W:0]   OUT_LIM  = (COS_W+1)'(OUTER_ENTRIES);
  localparam logic [COS_W:0]   HALF_LIM = (COS_W+1)'(OUTER_ENTRIES / 2);
  localparam logic [COS_W:0]   IN_LIM   = (COS_W+1)'(INNER_ENTRIES);

  logic [MASK_W-1:0] outerQ [OUTER_ENTRIES];
  logic [MASK_W-1:0] innerQ [INNER_ENTRIES];

  // Entry 0 of each bank is a constant default; the rest are writable
  for (genvar i = 0; i < OUTER_ENTRIES; i++) begin : gOuter
    if (i == 0) begin : gLock
      assign outerQ[i] = DEF_MASK;
    end else begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  outerQ[i] <= DEF_MASK;
        else if (stb.wrOuter && wrIdx == IDX_W'(i)) outerQ[i] <= wrMask;
      end
    end
  end

  for (genvar j = 0; j < INNER_ENTRIES; j++) begin : gInner
    if (j == 0) begin : gLock
      assign innerQ[j] = DEF_MASK;
    end else begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  innerQ[j] <= DEF_MASK;
        else if (stb.wrInner && wrIdx == IDX_W'(j)) innerQ[j] <= wrMask;
      end
    end
  end

  logic [COS_W:0]    cosExt;
  logic [MASK_W-1:0] lkNext;
  logic [MASK_W-1:0] rdNext;

  assign cosExt = {1'b0, lkCos};

  always_comb begin
    lkNext = DEF_MASK;
    if (lkCos != '0) begin
      if (lkOuter) begin
        if (splitQ) begin
          if (cosExt < HALF_LIM) lkNext = outerQ[{lkCos[IDX_W-2:0], lkCode}];
        end else if (cosExt < OUT_LIM) begin
          lkNext = outerQ[lkCos[IDX_W-1:0]];
        end
      end else if (cosExt < IN_LIM) begin
        lkNext = innerQ[lkCos[IN_W-1:0]];
      end
    end
  end

  always_comb begin
    if (rdOuter)                                          rdNext = outerQ[rdIdx];
    else if ({1'b0, rdIdx} < (IDX_W+1)'(INNER_ENTRIES))   rdNext = innerQ[rdIdx[IN_W-1:0]];
    else                                                  rdNext = DEF_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkMask <= DEF_MASK;
      rdMask <= DEF_MASK;
    end else begin
      lkMask <= lkNext;
      rdMask <= rdNext;
    end
  end

  // R3
  oneBank_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrOuter, stb.wrInner}));

  // R4
  noZeroMask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkMask != '0) && (rdMask != '0));

  // R2
  cosZeroDefault_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lkCos) == '0) |-> (lkMask == DEF_MASK));

  // R6
  outerBeyond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(lkOuter && !splitQ && (cosExt >= OUT_LIM)) |-> (lkMask == DEF_MASK));

  // R8
  splitBeyond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(lkOuter && splitQ && (cosExt >= HALF_LIM)) |-> (lkMask == DEF_MASK));

endmodule

// File: rtl/cosmask_table.sv
module cosmask_table
  import cosmask_pkg::*;
#(
  parameter int MASK_W        = 8,
  parameter int OUTER_ENTRIES = 16,
  parameter int INNER_ENTRIES = 8,
  parameter int COS_W         = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic                             wrOuter,
  input  logic [$clog2(OUTER_ENTRIES)-1:0] wrIdx,
  input  logic [MASK_W-1:0]                wrMask,
  input  logic                             modeWrEn,
  input  logic                             modeSplit,
  input  logic                             rdOuter,
  input  logic [$clog2(OUTER_ENTRIES)-1:0] rdIdx,
  output logic [MASK_W-1:0]                rdMask,
  input  logic [COS_W-1:0]                 lkCos,
  input  logic                             lkOuter,
  input  logic                             lkCode,
  output logic [MASK_W-1:0]                lkMask,
  output logic                             wrErr,
  output logic                             splitActive
);
  cmStrobe_t stb;
  logic      splitQ;

  cosmask_ctrl #(
    .MASK_W(MASK_W), .OUTER_ENTRIES(OUTER_ENTRIES), .INNER_ENTRIES(INNER_ENTRIES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOuter(wrOuter), .wrIdx(wrIdx),
    .wrMask(wrMask), .modeWrEn(modeWrEn), .modeSplit(modeSplit),
    .stb(stb), .wrErr(wrErr), .splitQ(splitQ)
  );

  cosmask_dp #(
    .MASK_W(MASK_W), .OUTER_ENTRIES(OUTER_ENTRIES), .INNER_ENTRIES(INNER_ENTRIES),
    .COS_W(COS_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .wrMask(wrMask),
    .splitQ(splitQ), .rdOuter(rdOuter), .rdIdx(rdIdx), .rdMask(rdMask),
    .lkCos(lkCos), .lkOuter(lkOuter), .lkCode(lkCode), .lkMask(lkMask)
  );

  assign splitActive = splitQ;

endmodule

// File: tb/cosmask_table_test.sv
`timescale 1ns/1ps
module cosmask_table_test;
  localparam int MW  = 8;
  localparam int NO  = 16;
  localparam int NI  = 8;
  localparam int CW  = 5;
  localparam int IW  = $clog2(NO);
  localparam int DEF = (1 << MW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrOuter = 0, modeWrEn = 0, modeSplit = 0, rdOuter = 0;
  logic lkOuter = 0, lkCode = 0;
  logic [IW-1:0] wrIdx = '0, rdIdx = '0;
  logic [MW-1:0] wrMask = '0;
  logic [CW-1:0] lkCos = '0;
  logic [MW-1:0] rdMask, lkMask;
  logic          wrErr, splitActive;

  always #2.5 clk = ~clk;

  cosmask_table uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOuter(wrOuter), .wrIdx(wrIdx),
    .wrMask(wrMask), .modeWrEn(modeWrEn), .modeSplit(modeSplit),
    .rdOuter(rdOuter), .rdIdx(rdIdx), .rdMask(rdMask), .lkCos(lkCos),
    .lkOuter(lkOuter), .lkCode(lkCode), .lkMask(lkMask), .wrErr(wrErr),
    .splitActive(splitActive)
  );

  int    checks = 0, errors = 0;
  string phase = "R1";
  bit    finished = 0;
  bit    armed = 0;

  // Behavioural reference state
  int outerM[NO];
  int innerM[NI];
  bit splitM;
  int expLk = DEF, expRd = DEF;
  bit expErr = 0, expSplit = 0;

  function automatic bit runLegal(int m);
    int state = 0;  // 0 before run, 1 inside run, 2 after run
    for (int b = 0; b < MW; b++) begin
      bit v = m[b];
      if (state == 0 && v) state = 1;
      else if (state == 1 && !v) state = 2;
      else if (state == 2 && v) return 0;
    end
    return state != 0;
  endfunction

  function automatic int modelLookup(int c, bit outer, bit code);
    if (c == 0) return DEF;
    if (!outer) return (c < NI) ? innerM[c] : DEF;
    if (splitM) return (c < NO / 2) ? outerM[2 * c + (code ? 1 : 0)] : DEF;
    return (c < NO) ? outerM[c] : DEF;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NO; i++) outerM[i] = DEF;
      for (int i = 0; i < NI; i++) innerM[i] = DEF;
      splitM = 0;
      expLk = DEF; expRd = DEF; expErr = 0; expSplit = 0;
    end else begin
      bit ok;
      expLk = modelLookup(int'(lkCos), lkOuter, lkCode);
      expRd = rdOuter ? outerM[rdIdx] : ((int'(rdIdx) < NI) ? innerM[rdIdx] : DEF);
      ok = runLegal(int'(wrMask)) && (wrOuter || int'(wrIdx) < NI);
      expErr = wrEn && !ok;
      if (wrEn && ok && wrIdx != 0) begin
        if (wrOuter) outerM[wrIdx] = int'(wrMask);
        else         innerM[wrIdx] = int'(wrMask);
      end
      if (modeWrEn) splitM = modeSplit;
      expSplit = splitM;
    end
    armed = 1;
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !finished) begin
      cmp("lkMask", int'(lkMask), expLk);
      cmp("rdMask", int'(rdMask), expRd);
      cmp("wrErr", int'(wrErr), int'(expErr));
      cmp("splitActive", int'(splitActive), int'(expSplit));
    end
  end

  task automatic idle();
    wrEn = 0; modeWrEn = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(bit outer, int idx, int m);
    wrEn = 1; wrOuter = outer; wrIdx = IW'(idx); wrMask = MW'(m);
    step();
  endtask

  task automatic rd(bit outer, int idx);
    rdOuter = outer; rdIdx = IW'(idx);
    step();
  endtask

  task automatic lk(int c, bit outer, bit code);
    lkCos = CW'(c); lkOuter = outer; lkCode = code;
    step();
  endtask

  task automatic setMode(bit s);
    modeWrEn = 1; modeSplit = s;
    step();
  endtask

  function automatic int runMask(int w, int s);
    return ((1 << w) - 1) << s;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    phase = "R1";
    for (int c = 0; c < 4; c++) lk(c, 1, 0);  // lookups sampled in reset (R1)
    rstN = 1;
    for (int c = 1; c < NO; c++) lk(c, 1, 0);  // R1: all default after reset
    for (int c = 1; c < NI; c++) rd(0, c);

    phase = "R2";
    wr(1, 0, 'h0F); wr(0, 0, 'h03);
    rd(1, 0); rd(0, 0); lk(0, 1, 0); lk(0, 0, 1);

    phase = "R3";
    for (int i = 1; i < NO; i++) begin
      int w = (i % MW) + 1;
      wr(1, i, runMask(w, (i * 3) % (MW - w + 1)));
    end
    for (int i = 1; i < NI; i++) wr(0, i, runMask(i, MW - i));
    for (int i = 0; i < NO; i++) rd(1, i);
    for (int i = 0; i < NO; i++) rd(0, i);

    phase = "R4";
    rd(1, 3);
    wr(1, 3, 'h00); wr(1, 3, 'h05); wr(1, 3, 'h81); wr(0, 2, 'hA0);
    rd(1, 3); rd(0, 2);

    phase = "R5";
    wr(0, 9, 'h01); wr(0, NI, 'hFF); rd(0, 1); rd(0, NI);

    phase = "R6";
    for (int c = 0; c < 32; c++) lk(c, 1, c[0]);

    phase = "R7";
    for (int c = 0; c < 32; c++) begin lk(c, 0, 0); lk(c, 0, 1); end

    phase = "R10";
    lkCos = 5; lkOuter = 1; lkCode = 0; wr(1, 5, 'h18);
    lk(5, 1, 0);
    lkCos = 2; lkOuter = 0; wr(0, 2, 'h07);
    lk(2, 0, 0);

    phase = "R9";
    lkCos = 3; lkOuter = 1; lkCode = 1; setMode(1);
    lk(3, 1, 1);

    phase = "R8";
    for (int c = 0; c < 32; c++) begin lk(c, 1, 0); lk(c, 1, 1); end
    for (int c = 0; c < NI; c++) lk(c, 0, 1);

    phase = "R9";
    setMode(0);
    for (int c = 0; c < NO; c++) lk(c, 1, 1);

    phase = "R4";
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom);
      if (r[0]) begin
        wrEn = 1; wrOuter = r[1]; wrIdx = IW'(r[7:4]);
        wrMask = r[2] ? MW'(runMask((r[10:8] % MW) + 1, 0) << r[13:11])
                      : MW'(r[21:14]);
      end
      if (r[22] && r[23]) begin modeWrEn = 1; modeSplit = r[24]; end
      rdOuter = r[25]; rdIdx = IW'(r[29:26]);
      lkCos = CW'($urandom); lkOuter = r[30]; lkCode = r[31];
      step();
    end

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule